// File: doc/BRIEF.md
# Parking Occupancy Counter

This block keeps a running tally of the cars inside a small lot, held as one BCD digit from 0 to 8. Two switch lines, idle high and pulled low by a car passing the entry or the exit sensor, are first brought onto the system clock by a two-flop synchroniser. Each line is then cleaned by a debouncing state machine. A count step happens when a press is released, that is, when the debounced line returns high.

The tally never wraps. A step toward a limit is masked while the lot sits at that limit, and the count is never reloaded with a fixed value. The opposite direction stays open: a full lot can still lose a car, and an empty lot can still gain one. A synchronous system reset, which also serves as the power-on reset, and a manual active-low clear both bring the tally to zero.

Each debouncer has four states. `DB_HIGH` is the accepted idle level. `DB_FALL` is a low level being timed, and it goes back to `DB_HIGH` on any high sample. It moves on to `DB_LOW` once the low has been seen for `STABLE_CYCLES` samples in a row. `DB_LOW` is the accepted pressed level. `DB_RISE` is a high level being timed, and it goes back to `DB_LOW` on any low sample. It moves on to `DB_HIGH` after `STABLE_CYCLES` high samples, and that move emits a one-cycle release event.

The tally has three states. `LOT_EMPTY` goes to `LOT_PARTIAL` on an entry. `LOT_PARTIAL` goes to `LOT_EMPTY` on an exit at a count of 1, and to `LOT_FULL` on an entry at a count of 7. `LOT_FULL` goes to `LOT_PARTIAL` on an exit. A clear sends every state to `LOT_EMPTY`.

Top module: `park_occupancy`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `occ_count` is 0, `lot_empty` is 1 and `lot_full` is 0.
- R2: One entry press followed by its release raises `occ_count` by exactly one, provided the count is below 8.
- R3: One exit press followed by its release lowers `occ_count` by exactly one, provided the count is above 0.
- R4: An exit release at a count of 0 is ignored, so the count stays 0 and never wraps to 9.
- R5: An entry release at a count of 8 is ignored, so the count stays 8.
- R6: At either limit the opposite direction still steps: an exit from 8 gives 7, and an entry from 0 gives 1.
- R7: A level on a switch line is accepted only after `STABLE_CYCLES` (default 16) consecutive equal synchronised samples. Bounces shorter than that cause no count step.
- R8: An entry release event and an exit release event in the same clock cycle cancel, and the count is unchanged.
- R9: `lot_full` is 1 exactly when `occ_count` is 8, and `lot_empty` is 1 exactly when it is 0. Both flags change on the same clock edge as the count.
- R10: Holding `clear_n` low clears the count to 0 once it has passed the two-flop synchroniser. This clear takes precedence over any count event.
- R11: `occ_count` is a 4-bit binary-coded decimal value that never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system and power-on reset |
| enter_n | input | 1 | Entry switch, active low, idles high |
| leave_n | input | 1 | Exit switch, active low, idles high |
| clear_n | input | 1 | Manual clear, active low |
| occ_count | output | 4 | Cars present, as a BCD digit from 0 to 8 |
| lot_full | output | 1 | High when the count is 8 |
| lot_empty | output | 1 | High when the count is 0 |

## Verification
A debouncer stuck in the wrong state shows up as a step that is missing or extra. It appears a fixed number of cycles after the release: two synchroniser stages, `STABLE_CYCLES` of timing, then one cycle each for the event and the tally. A tally state that disagrees with the count shows at once as a flag that contradicts `occ_count`. A missing mask shows as a wrap to 9, or as a climb past 8, on the cycle after the blocked event. The bench replays every stimulus through a behavioural model that uses run-length integers. It compares all three outputs on every cycle, so any divergence is reported in the cycle where it first appears.

// File: rtl/park_pkg.sv
package park_pkg;
    typedef enum logic [1:0] {
        DB_HIGH = 2'd0,
        DB_FALL = 2'd1,
        DB_LOW  = 2'd2,
        DB_RISE = 2'd3
    } deb_state_t;

    typedef enum logic [1:0] {
        LOT_EMPTY   = 2'd0,
        LOT_PARTIAL = 2'd1,
        LOT_FULL    = 2'd2
    } lot_state_t;
endpackage

// File: rtl/park_sync.sv
module park_sync #(
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RESET_VAL;
            q      <= RESET_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/park_debounce.sv
module park_debounce
    import park_pkg::*;
#(
    parameter int STABLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic release_evt
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    deb_state_t state, state_d;
    logic [CW-1:0] run, run_d;
    logic evt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= DB_HIGH;
            run         <= '0;
            release_evt <= 1'b0;
        end else begin
            state       <= state_d;
            run         <= run_d;
            release_evt <= evt_d;
        end
    end

    always_comb begin
        state_d = state;
        run_d   = run;
        evt_d   = 1'b0;
        unique case (state)
            DB_HIGH: if (!raw) begin
                state_d = DB_FALL;
                run_d   = CW'(1);
            end
            DB_FALL: begin
                if (raw) begin
                    state_d = DB_HIGH;
                    run_d   = '0;
                end else if (run == LAST) begin
                    state_d = DB_LOW;
                    run_d   = '0;
                end else begin
                    run_d = run + CW'(1);
                end
            end
            DB_LOW: if (raw) begin
                state_d = DB_RISE;
                run_d   = CW'(1);
            end
            DB_RISE: begin
                if (!raw) begin
                    state_d = DB_LOW;
                    run_d   = '0;
                end else if (run == LAST) begin
                    state_d = DB_HIGH;
                    run_d   = '0;
                    evt_d   = 1'b1;
                end else begin
                    run_d = run + CW'(1);
                end
            end
            default: begin
                state_d = DB_HIGH;
                run_d   = '0;
            end
        endcase
    end

    // R7: a release event lasts a single cycle
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        release_evt |=> !release_evt);
    // R7: an event is only emitted after the line has settled back to its idle level
    assert_settled_high_R7: assert property (@(posedge clk) disable iff (rst)
        release_evt |-> state == DB_HIGH);
endmodule

// File: rtl/park_tally.sv
module park_tally
    import park_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               up_evt,
    input  logic               dn_evt,
    output logic [DIGIT_W-1:0] count,
    output logic               full,
    output logic               empty
);
    localparam logic [DIGIT_W-1:0] CAP    = DIGIT_W'(1) << (DIGIT_W - 1);
    localparam logic [DIGIT_W-1:0] ONE    = DIGIT_W'(1);
    localparam logic [DIGIT_W-1:0] NEAR   = CAP - ONE;

    lot_state_t state, state_d;
    logic [DIGIT_W-1:0] count_d;
    logic up_ok, dn_ok;

    always_comb begin
        up_ok = up_evt && !dn_evt && (state != LOT_FULL);
        dn_ok = dn_evt && !up_evt && (state != LOT_EMPTY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LOT_EMPTY;
            count <= '0;
        end else begin
            state <= state_d;
            count <= count_d;
        end
    end

    always_comb begin
        state_d = state;
        count_d = count;
        if (clr) begin
            state_d = LOT_EMPTY;
            count_d = '0;
        end else begin
            if (up_ok) count_d = count + ONE;
            if (dn_ok) count_d = count - ONE;
            unique case (state)
                LOT_EMPTY:   if (up_ok) state_d = LOT_PARTIAL;
                LOT_PARTIAL: begin
                    if (dn_ok && count == ONE)  state_d = LOT_EMPTY;
                    if (up_ok && count == NEAR) state_d = LOT_FULL;
                end
                LOT_FULL:    if (dn_ok) state_d = LOT_PARTIAL;
                default:     state_d = LOT_EMPTY;
            endcase
        end
    end

    always_comb begin
        full  = (state == LOT_FULL);
        empty = (state == LOT_EMPTY);
    end

    assert_cap_R11: assert property (@(posedge clk) disable iff (rst)
        count <= CAP);
    assert_flags_R9: assert property (@(posedge clk) disable iff (rst)
        (full == (count == CAP)) && (empty == (count == '0)));
    assert_no_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && dn_evt && !up_evt && !clr) |=> count == '0);
    assert_hold_full_R5: assert property (@(posedge clk) disable iff (rst)
        (count == CAP && up_evt && !dn_evt && !clr) |=> count == CAP);
    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        (count < CAP && up_evt && !dn_evt && !clr) |=> count == $past(count) + ONE);
    assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
        (up_evt && dn_evt && !clr) |=> $stable(count));
    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);
endmodule

// File: rtl/park_occupancy.sv
module park_occupancy #(
    parameter int STABLE_CYCLES = 16,
    parameter int DIGIT_W       = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enter_n,
    input  logic               leave_n,
    input  logic               clear_n,
    output logic [DIGIT_W-1:0] occ_count,
    output logic               lot_full,
    output logic               lot_empty
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_lines;
    logic [NCH-1:0] synced;
    logic [NCH-1:0] evt;
    logic           clr_sync;

    assign raw_lines = {leave_n, enter_n};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        park_sync #(.RESET_VAL(1'b1)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw_lines[ch]),
            .q   (synced[ch])
        );
        park_debounce #(.STABLE_CYCLES(STABLE_CYCLES)) u_deb (
            .clk         (clk),
            .rst         (rst),
            .raw         (synced[ch]),
            .release_evt (evt[ch])
        );
    end

    park_sync #(.RESET_VAL(1'b1)) u_clr_sync (
        .clk (clk),
        .rst (rst),
        .d   (clear_n),
        .q   (clr_sync)
    );

    park_tally #(.DIGIT_W(DIGIT_W)) u_tally (
        .clk    (clk),
        .rst    (rst),
        .clr    (!clr_sync),
        .up_evt (evt[0]),
        .dn_evt (evt[1]),
        .count  (occ_count),
        .full   (lot_full),
        .empty  (lot_empty)
    );
endmodule

// File: tb/tb_park_occupancy.sv
module tb_park_occupancy;
    localparam int STABLE = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enter_n = 1'b1;
    logic leave_n = 1'b1;
    logic clear_n = 1'b1;
    logic [3:0] occ_count;
    logic lot_full, lot_empty;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    string tag = "R1";

    park_occupancy #(.STABLE_CYCLES(STABLE), .DIGIT_W(4)) dut (
        .clk(clk), .rst(rst), .enter_n(enter_n), .leave_n(leave_n),
        .clear_n(clear_n), .occ_count(occ_count),
        .lot_full(lot_full), .lot_empty(lot_empty)
    );

    always #4 clk = ~clk;

    // Behavioural reference: delay queues, run lengths and an integer tally
    bit q_in[$], q_lv[$], q_cl[$];
    int lvl_in, lvl_lv, run_in, run_lv;
    bit ev_in, ev_lv;
    int m_cnt;

    always @(posedge clk) begin
        bit s_in, s_lv, s_cl, nev_in, nev_lv;
        if (rst) begin
            q_in = {1'b1, 1'b1}; q_lv = {1'b1, 1'b1}; q_cl = {1'b1, 1'b1};
            lvl_in = 1; lvl_lv = 1; run_in = 0; run_lv = 0;
            ev_in = 0; ev_lv = 0; m_cnt = 0;
        end else begin
            s_in = q_in[0]; s_lv = q_lv[0]; s_cl = q_cl[0];
            if (!s_cl) m_cnt = 0;
            else if (ev_in && !ev_lv && m_cnt < 8) m_cnt++;
            else if (ev_lv && !ev_in && m_cnt > 0) m_cnt--;
            nev_in = 0; nev_lv = 0;
            if (int'(s_in) != lvl_in) begin
                run_in++;
                if (run_in == STABLE) begin
                    lvl_in = s_in; run_in = 0; nev_in = s_in;
                end
            end else run_in = 0;
            if (int'(s_lv) != lvl_lv) begin
                run_lv++;
                if (run_lv == STABLE) begin
                    lvl_lv = s_lv; run_lv = 0; nev_lv = s_lv;
                end
            end else run_lv = 0;
            ev_in = nev_in; ev_lv = nev_lv;
            void'(q_in.pop_front()); q_in.push_back(enter_n);
            void'(q_lv.pop_front()); q_lv.push_back(leave_n);
            void'(q_cl.pop_front()); q_cl.push_back(clear_n);
        end
    end

    task automatic check(input string t, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", t, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (compare_on && !rst) begin
            check(tag, occ_count, m_cnt, "count");
            check("R9", lot_full, (m_cnt == 8), "full");
            check("R9", lot_empty, (m_cnt == 0), "empty");
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input bit ent, input bit lv);
        @(negedge clk);
        if (ent) enter_n = 1'b0;
        if (lv) leave_n = 1'b0;
        wait_n(STABLE + 6);
        enter_n = 1'b1; leave_n = 1'b1;
        wait_n(STABLE + 8);
    endtask

    initial begin
        wait_n(5);
        // R1: reset state, both during reset and right after release
        check("R1", occ_count, 0, "count in reset");
        check("R1", lot_empty, 1, "empty in reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1", occ_count, 0, "count after reset");
        check("R1", lot_full, 0, "full after reset");
        compare_on = 1'b1;

        tag = "R4"; press(0, 1);
        check("R4", occ_count, 0, "exit at empty");
        tag = "R6"; press(1, 0);
        check("R6", occ_count, 1, "entry from empty");
        tag = "R2";
        for (int i = 0; i < 7; i++) press(1, 0);
        check("R2", occ_count, 8, "after eight entries");
        tag = "R5"; press(1, 0); press(1, 0);
        check("R5", occ_count, 8, "entry at full");
        check("R9", lot_full, 1, "full flag at 8");
        tag = "R6"; press(0, 1);
        check("R6", occ_count, 7, "exit from full");
        tag = "R3"; press(0, 1); press(0, 1);
        check("R3", occ_count, 5, "after exits");
        tag = "R8"; press(1, 1);
        check("R8", occ_count, 5, "simultaneous cancel");
        // R7: short bounces never reach the accepted level
        tag = "R7";
        for (int b = 0; b < 6; b++) begin
            enter_n = 1'b0; wait_n(STABLE - 4);
            enter_n = 1'b1; wait_n(3);
        end
        wait_n(STABLE + 8);
        check("R7", occ_count, 5, "bounce ignored");
        // R7: bouncing press then a clean hold still counts once
        for (int b = 0; b < 3; b++) begin
            enter_n = 1'b0; wait_n(2);
            enter_n = 1'b1; wait_n(2);
        end
        enter_n = 1'b0; wait_n(STABLE + 4);
        for (int b = 0; b < 3; b++) begin
            enter_n = 1'b1; wait_n(3);
            enter_n = 1'b0; wait_n(2);
        end
        enter_n = 1'b1; wait_n(STABLE + 8);
        check("R7", occ_count, 6, "bouncy press counted once");
        // R10: clear wins over a coincident entry release
        tag = "R10";
        enter_n = 1'b0; wait_n(STABLE + 6);
        enter_n = 1'b1; wait_n(STABLE);
        clear_n = 1'b0; wait_n(10);
        clear_n = 1'b1; wait_n(10);
        check("R10", occ_count, 0, "after clear");
        check("R9", lot_empty, 1, "empty after clear");
        tag = "R2"; press(1, 0);
        check("R2", occ_count, 1, "entry after clear");
        // R1: mid-run reset
        tag = "R1";
        press(1, 0);
        rst = 1'b1; wait_n(3); rst = 1'b0;
        @(negedge clk);
        check("R1", occ_count, 0, "count after second reset");
        wait_n(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule